// File: doc/BRIEF.md
# Wake-up Oscillator Settling Timer

This block governs the path from a low-power state back to normal operation. A one-cycle sleep request, tagged as either standby or watch, drops the CPU and peripheral clock enables. A wake-up interrupt then loads a down-counter with a wait length taken from a 3-bit select field. The enables stay low until that count runs out, which gives the oscillator time to settle.

The select encoding is not monotonic. Five codes give long power-of-two waits meant for a crystal. Three codes give short waits meant for an externally driven clock. A low-speed bit chooses whether the CPU comes back on the main system clock or on the slow subclock, but only when the block is leaving watch mode. A leave from standby always resumes on the system clock.

Both fields sit in one 8-bit control byte. It is written through a write strobe and is always readable. The select field and the low-speed bit are sampled when the wake-up starts, so a write made during a wait changes only the next one.

Top module: `wake_settle_top`

## Requirements
- R1: After reset the control byte reads 0x04: select 000, low-speed 0, and the fixed bit is 1. Both clock enables are high, `settle_ready` is low and `resume_sub` is 0.
- R2: The control byte is laid out as follows. Bits 6:4 hold the select field and bit 3 holds the low-speed bit, and a write with `reg_wr_en` loads both from `reg_wr_data`. Bit 2 always reads 1 and bits 7, 1 and 0 always read 0, whatever was written.
- R3: Select codes 000, 001, 010, 011 and 100 give waits of 8192, 16384, 32768, 65536 and 131072 cycles. The wait length N is counted as follows: `settle_ready` goes high N clock edges after the cycle in which `wake_irq` was sampled high in the low-power state.
- R4: Select code 101 gives a 2-cycle wait (external clock), 110 gives 8 cycles and 111 gives 16 cycles, measured as in R3.
- R5: A `sleep_req` seen while running makes both enables low from the next cycle. They stay low through the low-power state and the whole wait, and they rise only in the cycle where `settle_ready` is high.
- R6: `wake_irq` while running has no effect: no wait starts, `settle_ready` stays low and the enables stay high.
- R7: The select code is captured when the wake-up interrupt is accepted. A register write during the wait does not change that wait's length, although it does update the read-back value.
- R8: Further `wake_irq` pulses during a wait neither restart it nor lengthen it, and they produce no extra `settle_ready` pulse.
- R9: `settle_ready` is a one-cycle pulse. Both enables are high in that cycle and stay high after it.
- R10: `resume_sub` is updated when a wake-up is accepted and is otherwise unchanged while running. It becomes 1 only for a leave from watch mode (`sleep_watch`=1 at the request) with the low-speed bit at 1. It becomes 0 for a leave from watch with the bit at 0 and for any leave from standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one state is one cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control byte |
| reg_wr_data | input | 8 | Write data for the control byte |
| reg_rd_data | output | 8 | Current control byte |
| sleep_req | input | 1 | One-cycle request to enter low power |
| sleep_watch | input | 1 | Qualifies sleep_req: 1 = watch, 0 = standby |
| wake_irq | input | 1 | Wake-up interrupt |
| settle_ready | output | 1 | One-cycle pulse at the end of the wait |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| resume_sub | output | 1 | 1 = resume on subclock, 0 = system clock |

## Verification
Some properties are checked by assertions on every cycle:
- the fixed bits of the control byte;
- `settle_ready` being a one-cycle pulse with both enables high;
- the enables falling after a sleep request and rising only together with `settle_ready`;
- the absence of any ready pulse or `resume_sub` change while running.

The bench scenarios show what a cycle-local property cannot:
- the exact wait length for each select code, both the short codes and the long ones;
- the capture of the select code when the wait starts, even when a write arrives mid-wait;
- the immunity of a running wait to repeated interrupts;
- the resume clock choice for each mode and low-speed setting.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 3;
  localparam int SEL_LSB = 4;
  localparam int LS_POS  = 3;
  localparam int FIX_POS = 2;

  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_LOW    = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;
endpackage

// File: rtl/wk_regs.sv
module wk_regs
  import wk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [SEL_W-1:0] sel,
  output logic             lson
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[REG_W-1], wr_data[FIX_POS:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      lson <= 1'b0;
    end else if (wr_en) begin
      sel  <= wr_data[SEL_LSB +: SEL_W];
      lson <= wr_data[LS_POS];
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[SEL_LSB +: SEL_W] = sel;
    rd_data[LS_POS]           = lson;
    rd_data[FIX_POS]          = 1'b1;
  end
endmodule

// File: rtl/wk_wait_decode.sv
module wk_wait_decode
  import wk_pkg::*;
#(
  parameter int LONG_LOG2  = 13,
  parameter int LONG_CODES = 5,
  parameter int SHORT0     = 2,
  parameter int SHORT1     = 8,
  parameter int SHORT2     = 16,
  localparam int CNT_W     = LONG_LOG2 + LONG_CODES - 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] load_val
);
  logic [CNT_W-1:0] long_tab  [LONG_CODES];
  logic [CNT_W-1:0] short_tab [3];

  for (genvar g = 0; g < LONG_CODES; g++) begin : g_long
    assign long_tab[g] = CNT_W'((64'd1 << (LONG_LOG2 + g)) - 64'd1);
  end

  assign short_tab[0] = CNT_W'(SHORT0 - 1);
  assign short_tab[1] = CNT_W'(SHORT1 - 1);
  assign short_tab[2] = CNT_W'(SHORT2 - 1);

  always_comb begin
    load_val = '0;
    for (int i = 0; i < LONG_CODES; i++)
      if (sel == SEL_W'(i)) load_val = long_tab[i];
    for (int j = 0; j < 3; j++)
      if (sel == SEL_W'(LONG_CODES + j)) load_val = short_tab[j];
  end
endmodule

// File: rtl/wk_settle_cnt.sv
module wk_settle_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic sleep_watch,
  input  logic wake_irq,
  input  logic lson,
  input  logic cnt_zero,
  output logic cnt_load,
  output logic cnt_run,
  output logic ready,
  output logic cpu_en,
  output logic per_en,
  output logic resume_sub
);
  phase_e phase;
  logic   in_watch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_RUN;
      in_watch   <= 1'b0;
      resume_sub <= 1'b0;
    end else begin
      unique case (phase)
        PH_RUN: if (sleep_req) begin
          phase    <= PH_LOW;
          in_watch <= sleep_watch;
        end
        PH_LOW: if (wake_irq) begin
          phase      <= PH_SETTLE;
          resume_sub <= in_watch & lson;
        end
        PH_SETTLE: if (cnt_zero) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign cnt_load = (phase == PH_LOW) && wake_irq;
  assign cnt_run  = (phase == PH_SETTLE);
  assign ready    = (phase == PH_SETTLE) && cnt_zero;
  assign cpu_en   = (phase == PH_RUN) || ready;
  assign per_en   = (phase == PH_RUN) || ready;
endmodule

// File: rtl/wake_settle_top.sv
module wake_settle_top
  import wk_pkg::*;
#(
  parameter int LONG_LOG2  = 13,
  parameter int LONG_CODES = 5,
  parameter int SHORT0     = 2,
  parameter int SHORT1     = 8,
  parameter int SHORT2     = 16,
  localparam int CNT_W     = LONG_LOG2 + LONG_CODES - 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  output logic [7:0] reg_rd_data,
  input  logic       sleep_req,
  input  logic       sleep_watch,
  input  logic       wake_irq,
  output logic       settle_ready,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       resume_sub
);
  logic [SEL_W-1:0] sel;
  logic             lson;
  logic [CNT_W-1:0] load_val;
  logic             cnt_load, cnt_run, cnt_zero;

  wk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .rd_data(reg_rd_data), .sel(sel), .lson(lson)
  );

  wk_wait_decode #(
    .LONG_LOG2(LONG_LOG2), .LONG_CODES(LONG_CODES),
    .SHORT0(SHORT0), .SHORT1(SHORT1), .SHORT2(SHORT2)
  ) u_dec (
    .sel(sel), .load_val(load_val)
  );

  wk_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
    .run(cnt_run), .zero(cnt_zero)
  );

  wk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_watch(sleep_watch),
    .wake_irq(wake_irq), .lson(lson), .cnt_zero(cnt_zero),
    .cnt_load(cnt_load), .cnt_run(cnt_run), .ready(settle_ready),
    .cpu_en(cpu_clk_en), .per_en(per_clk_en), .resume_sub(resume_sub)
  );
endmodule

// File: rtl/wake_settle_chk.sv
module wake_settle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [7:0] reg_rd_data,
  input logic       settle_ready,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       resume_sub
);
  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[2] && !reg_rd_data[7] && reg_rd_data[1:0] == 2'b00);

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    settle_ready |=> !settle_ready && cpu_clk_en && per_clk_en);

  assert_ready_enables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    settle_ready |-> cpu_clk_en && per_clk_en);

  assert_sleep_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !settle_ready && sleep_req) |=> (!cpu_clk_en && !per_clk_en));

  assert_rise_with_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) || $rose(per_clk_en)) |-> settle_ready);

  assert_no_ready_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !settle_ready) |=> !settle_ready);

  assert_resume_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !settle_ready) |=> $stable(resume_sub));
endmodule

bind wake_settle_top wake_settle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .reg_rd_data(reg_rd_data),
  .settle_ready(settle_ready), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .resume_sub(resume_sub)
);

// File: tb/test_wake_settle_top.sv
module test_wake_settle_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       sleep_req = 1'b0;
  logic       sleep_watch = 1'b0;
  logic       wake_irq = 1'b0;
  logic       settle_ready, cpu_clk_en, per_clk_en, resume_sub;

  wake_settle_top i_wake_settle_top (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .sleep_req(sleep_req), .sleep_watch(sleep_watch),
    .wake_irq(wake_irq), .settle_ready(settle_ready), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .resume_sub(resume_sub)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    bit    sub;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   low_bad = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] rd_of(logic [7:0] d);
    return {1'b0, d[6:4], d[3], 3'b100};
  endfunction

  // monitor: pops the scoreboard on each ready pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && !settle_ready && (cpu_clk_en || per_clk_en)) low_bad = 1;
      if (settle_ready) begin
        if (q.size() == 0) begin
          check(0, "R6/R8 unexpected ready", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.due, {e.tag, " wait length"}, cyc, e.due);
          check(resume_sub == e.sub, "R10 resume_sub", resume_sub, e.sub);
          check(!low_bad, "R5 enables low during wait", low_bad, 0);
          low_bad = 0;
        end
      end
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
    check(reg_rd_data == rd_of(d), "R2 readback", reg_rd_data, rd_of(d));
  endtask

  task automatic go_sleep(bit watch);
    @(negedge clk);
    sleep_req = 1; sleep_watch = watch;
    @(negedge clk);
    sleep_req = 0;
    check(!cpu_clk_en && !per_clk_en, "R5 enables drop after sleep",
          {cpu_clk_en, per_clk_en}, 0);
  endtask

  task automatic start_wake(int n, bit sub, string tag);
    exp_t e;
    @(negedge clk);
    wake_irq = 1;
    e.due = cyc + n; e.sub = sub; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    wake_irq = 0;
  endtask

  task automatic finish_wake();
    while (!settle_ready) @(negedge clk);
    @(negedge clk);
    check(!settle_ready && cpu_clk_en && per_clk_en, "R9 pulse and enables held",
          {settle_ready, cpu_clk_en, per_clk_en}, 3);
  endtask

  task automatic full(logic [7:0] d, bit watch, int n, bit sub, string tag);
    wr(d);
    go_sleep(watch);
    repeat (3) @(negedge clk);
    start_wake(n, sub, tag);
    finish_wake();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(reg_rd_data == 8'h04, "R1 reset byte", reg_rd_data, 8'h04);
    check(cpu_clk_en && per_clk_en && !settle_ready && !resume_sub, "R1 reset outputs",
          {cpu_clk_en, per_clk_en, settle_ready, resume_sub}, 4'b1100);
    // R2 fixed and unused bits
    wr(8'hFF);
    wr(8'h00);
    // R6 interrupt while running
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    repeat (20) @(negedge clk);
    check(cpu_clk_en && per_clk_en && !settle_ready, "R6 irq ignored while running",
          {cpu_clk_en, per_clk_en, settle_ready}, 3'b110);
    // R4 short codes, R10 resume choice
    full(8'h50, 1'b0, 2,  1'b0, "R4 code101");
    full(8'h68, 1'b1, 8,  1'b1, "R4 code110");
    full(8'h70, 1'b1, 16, 1'b0, "R4 code111");
    full(8'h58, 1'b0, 2,  1'b0, "R10 standby ignores lowspeed");
    // R7 write during wait
    wr(8'h60);
    go_sleep(1'b1);
    start_wake(8, 1'b0, "R7 captured select");
    wr(8'h58);
    finish_wake();
    check(reg_rd_data == 8'h5C, "R7 write landed", reg_rd_data, 8'h5C);
    // R8 repeated interrupts
    wr(8'h70);
    go_sleep(1'b0);
    start_wake(16, 1'b0, "R8 no restart");
    repeat (4) @(negedge clk);
    wake_irq = 1; @(negedge clk); wake_irq = 0;
    repeat (3) @(negedge clk);
    wake_irq = 1; @(negedge clk); wake_irq = 0;
    finish_wake();
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R8 no extra pulse", q.size(), 0);
    // R3 long codes
    full(8'h00, 1'b1, 8192,   1'b0, "R3 code000");
    full(8'h18, 1'b1, 16384,  1'b1, "R3 code001");
    full(8'h40, 1'b0, 131072, 1'b0, "R3 code100");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    done = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule